// File: doc/BRIEF.md
# Three-Pulse Bus Request/Grant Handler

This block lends the local bus to outside bus masters. Each master owns one single-wire channel that idles high and carries all of its handshake as one-clock low pulses. The master pulses low once to ask for the bus. The block answers with a one-clock low pulse of its own on the same wire, which grants the bus. The master pulses low once more to give the bus back. Between the grant and the return, the block raises a hold acknowledge that tells the pad logic to float the bus, and it stalls the bus sequencer.

The block watches the sequencer's current bus phase. It also watches three qualifiers: a locked instruction is running, the current cycle is the first of an interrupt-acknowledge pair, and the current cycle is the first half of a word split across an odd address. From these it decides when a grant may be issued. A grant can go out after an idle clock or after the T4 clock of an eligible cycle. Lower-numbered channels win ties. After every return, one dead clock passes before the bus can change hands again.

Top module: `rg_handler`

## Requirements
- R1: While reset is high and in the first clock after it, no channel is pulled low, and `hold_ack`, `seq_stall` and `owner` are all zero.
- R2: Suppose a channel's wire is low for one clock (a request) while `bus_phase` is 0 (idle) and `lock_on` is low. The block then pulls that channel's wire low through `rg_pull[c]` for exactly one clock, two clocks after the request clock. At most one `rg_pull` bit is ever high.
- R3: `hold_ack` and `owner[c]` are high from the clock after the grant pulse. `hold_ack` stays high until the owner pulses its wire low (the release), and it is low again in the clock after the release clock.
- R4: `seq_stall` is high during the grant clock and every hold clock. It stays high for exactly one dead clock after `hold_ack` falls, and no grant is issued in that dead clock.
- R5: While a bus cycle is running, a grant is issued only in the clock after a clock whose `bus_phase` is 5 (T4). The request must have been seen while `bus_phase` was 0, 1 or 2 (idle, T1 or T2). Phase codes 3 and 4 are T3 and TW.
- R6: A request seen while `bus_phase` is 3, 4 or 5 is not granted at that cycle's T4. It stays pending and is granted after the T4 of the next bus cycle.
- R7: A T4 in which `split_first` or `inta_first` is high does not issue a grant. The request stays pending for a later eligible T4.
- R8: No grant is issued while `lock_on` is high, in either idle or T4. A request recorded during the lock is granted in the clock after the first eligible clock in which `lock_on` is low.
- R9: When more than one channel is pending and eligible, channel 0 is granted first (bit 0 of `rg_line`/`rg_pull`). The other channel is granted after the first exchange and its dead clock.
- R10: The block's own grant pulse is not taken as a new request. A low pulse from the owner during the hold is a release, not a request. A request from another channel during the hold is kept and served afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rg_line | input | NCH | Sensed level of each request/grant wire (low = pulse) |
| bus_phase | input | 3 | Sequencer phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| lock_on | input | 1 | A locked instruction is running |
| inta_first | input | 1 | Current cycle is the first interrupt acknowledge |
| split_first | input | 1 | Current cycle is the first half of an odd-address word |
| rg_pull | output | NCH | Pull the channel's wire low (grant pulse) |
| hold_ack | output | 1 | Bus is lent out; pads float |
| seq_stall | output | 1 | Sequencer must not start a new T1 |
| owner | output | NCH | One-hot channel holding or being granted the bus |

## Verification
A lost pending bit shows up at the ports as a grant pulse that never appears. A request wrongly marked late or early shows up as a grant that comes one bus cycle late or one cycle early, at the first T4 that follows. A state machine that slips out of the hold or dead state is visible within one clock, as a `hold_ack` or `seq_stall` edge that is misplaced or missing. A mistaken self-request from the block's own pulse appears as an extra grant three clocks after a release. The bench therefore pins each grant, hold edge and stall edge to an exact clock number and checks it there.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int PHASE_W = 3;

  localparam logic [PHASE_W-1:0] PH_IDLE = 3'd0;
  localparam logic [PHASE_W-1:0] PH_T1   = 3'd1;
  localparam logic [PHASE_W-1:0] PH_T2   = 3'd2;
  localparam logic [PHASE_W-1:0] PH_T3   = 3'd3;
  localparam logic [PHASE_W-1:0] PH_TW   = 3'd4;
  localparam logic [PHASE_W-1:0] PH_T4   = 3'd5;

  typedef enum logic [1:0] {
    XS_WATCH = 2'd0,
    XS_GRANT = 2'd1,
    XS_HELD  = 2'd2,
    XS_DEAD  = 2'd3
  } xchg_state_e;

  // A request noticed in one of these phases is early enough for this cycle.
  function automatic logic phase_is_early(logic [PHASE_W-1:0] ph);
    return (ph == PH_IDLE) || (ph == PH_T1) || (ph == PH_T2);
  endfunction
endpackage

// File: rtl/rg_line_sense.sv
module rg_line_sense (
  input  logic clk,
  input  logic rst,
  input  logic line_lvl,
  input  logic self_pull,
  output logic fall
);
  logic eff;
  logic prev_q;

  // The block's own pull is masked so it never reads as a master pulse.
  assign eff  = line_lvl | self_pull;
  assign fall = prev_q & ~eff;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= eff;
  end
endmodule

// File: rtl/rg_pending.sv
module rg_pending (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic set_early,
  input  logic age_early,
  input  logic clr,
  output logic pend,
  output logic early
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      early <= 1'b0;
    end else if (clr) begin
      pend  <= 1'b0;
      early <= 1'b0;
    end else if (set_req && !pend) begin
      pend  <= 1'b1;
      early <= set_early;
    end else if (pend) begin
      early <= early | age_early;
    end
  end
endmodule

// File: rtl/rg_pick.sv
module rg_pick #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] win
);
  for (genvar c = 0; c < NCH; c++) begin : g_win
    if (c == 0) begin : g_top
      assign win[c] = elig[c];
    end else begin : g_low
      assign win[c] = elig[c] & ~(|elig[c-1:0]);
    end
  end
endmodule

// File: rtl/rg_handler.sv
module rg_handler #(
  parameter int NCH = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCH-1:0]              rg_line,
  input  logic [rg_pkg::PHASE_W-1:0]  bus_phase,
  input  logic                        lock_on,
  input  logic                        inta_first,
  input  logic                        split_first,
  output logic [NCH-1:0]              rg_pull,
  output logic                        hold_ack,
  output logic                        seq_stall,
  output logic [NCH-1:0]              owner
);
  import rg_pkg::*;

  xchg_state_e    st_q, st_n;
  logic [NCH-1:0] fall, req_set, pend, early, elig, win, clr;
  logic           slot_idle, slot_t4, t4_ok, released, ph_early;

  assign slot_idle = (bus_phase == PH_IDLE);
  assign slot_t4   = (bus_phase == PH_T4);
  assign t4_ok     = slot_t4 & ~split_first & ~inta_first;
  assign ph_early  = phase_is_early(bus_phase);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rg_line_sense u_sense (
      .clk       (clk),
      .rst       (rst),
      .line_lvl  (rg_line[c]),
      .self_pull (rg_pull[c]),
      .fall      (fall[c])
    );

    assign req_set[c] = fall[c] & ~owner[c];
    assign clr[c]     = (st_q == XS_WATCH) & win[c];

    rg_pending u_pend (
      .clk       (clk),
      .rst       (rst),
      .set_req   (req_set[c]),
      .set_early (ph_early),
      .age_early (ph_early),
      .clr       (clr[c]),
      .pend      (pend[c]),
      .early     (early[c])
    );

    assign elig[c] = (st_q == XS_WATCH) & pend[c] & ~lock_on &
                     (slot_idle | (t4_ok & early[c]));
  end

  rg_pick #(.NCH(NCH)) u_pick (
    .elig (elig),
    .win  (win)
  );

  assign released = (st_q == XS_HELD) & (|(fall & owner));

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      XS_WATCH: if (|win)    st_n = XS_GRANT;
      XS_GRANT:              st_n = XS_HELD;
      XS_HELD:  if (released) st_n = XS_DEAD;
      XS_DEAD:               st_n = XS_WATCH;
      default:               st_n = XS_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= XS_WATCH;
      rg_pull   <= '0;
      owner     <= '0;
      hold_ack  <= 1'b0;
      seq_stall <= 1'b0;
    end else begin
      st_q      <= st_n;
      rg_pull   <= (st_q == XS_WATCH) ? win : '0;
      hold_ack  <= (st_n == XS_HELD);
      seq_stall <= (st_n != XS_WATCH);
      if ((st_q == XS_WATCH) && (|win)) owner <= win;
      else if (released)                owner <= '0;
    end
  end
endmodule

// File: rtl/rg_handler_chk.sv
module rg_handler_chk #(
  parameter int NCH = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [2:0]                 bus_phase,
  input logic                       lock_on,
  input logic                       inta_first,
  input logic                       split_first,
  input logic [NCH-1:0]             rg_pull,
  input logic                       hold_ack,
  input logic                       seq_stall,
  input logic [NCH-1:0]             owner
);
  p_pull_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rg_pull));
  p_pull_single_r2: assert property (@(posedge clk) disable iff (rst)
    (|rg_pull) |=> (rg_pull == '0));
  p_hold_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (|rg_pull) |=> (hold_ack && $onehot(owner)));
  p_hold_stalls_r4: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> seq_stall);
  p_dead_clock_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> (seq_stall && (rg_pull == '0)));
  p_dead_ends_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |=> !seq_stall);
  p_grant_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (|rg_pull) |-> ($past(bus_phase) == 3'd0 || $past(bus_phase) == 3'd5));
  p_t4_quals_r7: assert property (@(posedge clk) disable iff (rst)
    ((|rg_pull) && $past(bus_phase) == 3'd5) |-> (!$past(split_first) && !$past(inta_first)));
  p_lock_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (|rg_pull) |-> !$past(lock_on));
endmodule

bind rg_handler rg_handler_chk #(.NCH(NCH)) u_rg_handler_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_phase   (bus_phase),
  .lock_on     (lock_on),
  .inta_first  (inta_first),
  .split_first (split_first),
  .rg_pull     (rg_pull),
  .hold_ack    (hold_ack),
  .seq_stall   (seq_stall),
  .owner       (owner)
);

// File: tb/test_rg_handler.sv
module test_rg_handler;
  localparam int NCH = 2;
  localparam logic [2:0] I = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, TW = 3'd4, T4 = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] m_n = '1;
  logic [2:0] phase = I;
  logic lock_v = 1'b0, inta_v = 1'b0, split_v = 1'b0;
  logic [NCH-1:0] rg_line, rg_pull, owner;
  logic hold_ack, seq_stall;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] pull;
    logic       hold;
    logic       stall;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rg_line = m_n & ~rg_pull;

  rg_handler #(.NCH(NCH)) i_rg_handler (
    .clk(clk), .rst(rst), .rg_line(rg_line), .bus_phase(phase),
    .lock_on(lock_v), .inta_first(inta_v), .split_first(split_v),
    .rg_pull(rg_pull), .hold_ack(hold_ack), .seq_stall(seq_stall), .owner(owner)
  );

  task automatic expv(int k, logic [1:0] p, logic h, logic s, string r);
    exp_t e;
    e.at = k; e.pull = p; e.hold = h; e.stall = s; e.req = r;
    sb.push_back(e);
  endtask

  // Monitor: compares the expected items against the ports mid-cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
      end else if (rg_pull !== e.pull || hold_ack !== e.hold || seq_stall !== e.stall) begin
        fails++;
        $display("FAIL %s @%0d: pull/hold/stall actual %b/%b/%b expected %b/%b/%b",
                 e.req, cyc, rg_pull, hold_ack, seq_stall, e.pull, e.hold, e.stall);
      end
    end
  end

  task automatic step(logic [2:0] ph, logic lk, logic sp, logic ia, logic [1:0] mn);
    @(posedge clk); #1;
    phase = ph; lock_v = lk; split_v = sp; inta_v = ia; m_n = mn;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(I, 0, 0, 0, 2'b11);
  endtask

  task automatic release_ch(int ch, output int r);
    logic [1:0] mn;
    mn = 2'b11;
    mn[ch] = 1'b0;
    step(I, 0, 0, 0, mn);
    r = cyc;
    expv(r,     2'b00, 1, 1, "R3");
    expv(r + 1, 2'b00, 0, 1, "R4");
  endtask

  int a, r, r2;

  initial begin
    // R1: reset state
    step(I, 0, 0, 0, 2'b11);
    step(I, 0, 0, 0, 2'b11);
    expv(cyc, 2'b00, 0, 0, "R1");
    step(I, 0, 0, 0, 2'b11);
    rst = 1'b0;
    expv(cyc + 1, 2'b00, 0, 0, "R1");
    idle_n(2);

    // R2/R3/R4/R10: idle bus, channel 0
    step(I, 0, 0, 0, 2'b10); a = cyc;
    expv(a + 1, 2'b00, 0, 0, "R2");
    expv(a + 2, 2'b01, 0, 1, "R2");
    expv(a + 3, 2'b00, 1, 1, "R3");
    expv(a + 4, 2'b00, 1, 1, "R3");
    idle_n(4);
    release_ch(0, r);
    expv(r + 2, 2'b00, 0, 0, "R4");
    expv(r + 3, 2'b00, 0, 0, "R10");
    expv(r + 4, 2'b00, 0, 0, "R10");
    idle_n(5);

    // R5: request in T2, granted after T4
    step(T1, 0, 0, 0, 2'b11); a = cyc;
    step(T2, 0, 0, 0, 2'b10);
    step(T3, 0, 0, 0, 2'b11);
    step(T4, 0, 0, 0, 2'b11);
    expv(a + 3, 2'b00, 0, 0, "R5");
    expv(a + 4, 2'b01, 0, 1, "R5");
    expv(a + 5, 2'b00, 1, 1, "R5");
    idle_n(3);
    release_ch(0, r);
    idle_n(3);

    // R6: request in T3 is late for this cycle
    step(T1, 0, 0, 0, 2'b11); a = cyc;
    step(T2, 0, 0, 0, 2'b11);
    step(T3, 0, 0, 0, 2'b10);
    step(T4, 0, 0, 0, 2'b11);
    expv(a + 4, 2'b00, 0, 0, "R6");
    step(T1, 0, 0, 0, 2'b11);
    step(T2, 0, 0, 0, 2'b11);
    step(TW, 0, 0, 0, 2'b11);
    step(T4, 0, 0, 0, 2'b11);
    expv(a + 8, 2'b01, 0, 1, "R6");
    expv(a + 9, 2'b00, 1, 1, "R6");
    idle_n(3);
    release_ch(0, r);
    idle_n(3);

    // R7: split first half, then first INTA, then a clean T4
    step(T1, 0, 0, 0, 2'b01); a = cyc;
    step(T2, 0, 0, 0, 2'b11);
    step(T3, 0, 0, 0, 2'b11);
    step(T4, 0, 1, 0, 2'b11);
    expv(a + 4, 2'b00, 0, 0, "R7");
    step(T1, 0, 0, 0, 2'b11);
    step(T2, 0, 0, 0, 2'b11);
    step(T3, 0, 0, 0, 2'b11);
    step(T4, 0, 0, 1, 2'b11);
    expv(a + 8, 2'b00, 0, 0, "R7");
    step(T1, 0, 0, 0, 2'b11);
    step(T2, 0, 0, 0, 2'b11);
    step(T3, 0, 0, 0, 2'b11);
    step(T4, 0, 0, 0, 2'b11);
    expv(a + 12, 2'b10, 0, 1, "R7");
    idle_n(3);
    release_ch(1, r);
    idle_n(3);

    // R8: lock holds the request back until it drops
    step(I, 1, 0, 0, 2'b01); a = cyc;
    for (int k = 2; k <= 5; k++) expv(a + k, 2'b00, 0, 0, "R8");
    for (int k = 0; k < 4; k++) step(I, 1, 0, 0, 2'b11);
    step(I, 0, 0, 0, 2'b11);
    expv(a + 6, 2'b10, 0, 1, "R8");
    expv(a + 7, 2'b00, 1, 1, "R8");
    idle_n(3);
    release_ch(1, r);
    idle_n(3);

    // R9: simultaneous requests, channel 0 first
    step(I, 0, 0, 0, 2'b00); a = cyc;
    expv(a + 2, 2'b01, 0, 1, "R9");
    idle_n(4);
    release_ch(0, r);
    expv(r + 2, 2'b00, 0, 0, "R9");
    expv(r + 3, 2'b10, 0, 1, "R9");
    expv(r + 4, 2'b00, 1, 1, "R9");
    idle_n(5);
    release_ch(1, r2);
    idle_n(3);

    // R10: request from channel 0 during channel 1's hold
    step(I, 0, 0, 0, 2'b01); a = cyc;
    expv(a + 2, 2'b10, 0, 1, "R10");
    idle_n(3);
    step(I, 0, 0, 0, 2'b10);
    expv(a + 4, 2'b00, 1, 1, "R10");
    expv(a + 5, 2'b00, 1, 1, "R10");
    idle_n(2);
    release_ch(1, r);
    expv(r + 2, 2'b00, 0, 0, "R10");
    expv(r + 3, 2'b01, 0, 1, "R10");
    expv(r + 4, 2'b00, 1, 1, "R10");
    idle_n(5);
    release_ch(0, r2);
    expv(r2 + 2, 2'b00, 0, 0, "R4");
    idle_n(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule